// File: doc/BRIEF.md
# Receive descriptor ring engine

This block moves received Ethernet frames from a byte stream into memory buffers. Software sets up a ring of eight-byte descriptors. Each descriptor holds a status halfword, a length halfword and a buffer address. Software then pulses a kick strobe. The engine fetches descriptors one after another and fills each buffer with frame bytes. It then writes the descriptor back, handing it to software by clearing its Empty bit, and raises a frame-received event.

Ownership moves through the Empty bit. When the engine meets a descriptor that software still owns, it stops and waits for the next kick. A Wrap flag inside a descriptor sends the next fetch back to the ring base. A frame larger than the programmed buffer size continues into the following descriptor. A frame that starts while the engine is stopped is consumed, thrown away and counted.

The state machine has these states:
- ST_IDLE: stopped; frame bytes are discarded.
- ST_RD_STAT: read word 0 of the descriptor.
- ST_RD_BUF: read the buffer address.
- ST_COLLECT: pack frame bytes into a word.
- ST_WR_DATA: write the packed word.
- ST_WR_STAT: write the descriptor back.

The transitions are:
- ST_IDLE to ST_RD_STAT on a kick.
- ST_RD_STAT to ST_RD_BUF when the Empty bit is set, or to ST_IDLE when it is clear.
- ST_RD_BUF to ST_COLLECT when the read completes.
- ST_COLLECT to ST_WR_DATA on a frame end, a full word, or a full buffer.
- ST_WR_DATA to ST_WR_STAT when the frame is done or the buffer is full, otherwise back to ST_COLLECT.
- ST_WR_STAT to ST_RD_STAT for the next descriptor.

Top module: `rxring_engine`

## Requirements
- R1: After reset the engine is stopped. It makes no memory request until the kick, `rx_ready` is 1, `evt_flag` is 0 and `drop_count` is 0.
- R2: A kick while stopped reads word 0 at the ring base with address bits 3:0 forced to zero, then reads word 1 at base+4 as the buffer address. Word 0 carries the status in bits 31:16 and the length in bits 15:0.
- R3: If the fetched status has Empty (status bit 15, word bit 31) clear, the engine stops and makes no further request until the next kick.
- R4: Byte n of a descriptor's share of a frame is stored at buffer address + n. The byte at address a goes in lane a mod 4, which is word bits 8*(a mod 4)+7 down to 8*(a mod 4). Each write uses byte enables, so bytes after the frame end in the last word stay unchanged.
- R5: Closing a frame rewrites word 0 as follows:
  - Empty (bit 15) is 0.
  - Last (bit 11) is 1.
  - Wrap (bit 13) is copied from the fetch.
  - Bit 0 is 1 if `rx_err` was high on any byte of the frame.
  - All other status bits are 0.
  - The length is the number of frame bytes in that descriptor. The stream carries the four check bytes, and they are counted.
- R6: After the descriptor whose Wrap bit was set, the next fetch is at the ring base. Otherwise the next fetch is at the current descriptor address + 8.
- R7: A frame longer than `cfg_buf_size` fills the buffer. That descriptor is closed with length `cfg_buf_size`, Last 0 and Empty 0, and the frame continues in the next descriptor. Only the final descriptor gets Last.
- R8: `evt_flag` goes high the cycle after a Last-closing status write is accepted. A pulse on `evt_clr` clears it; if a set and a clear fall in the same cycle, the set wins. `irq` equals `evt_flag` AND `irq_en`.
- R9: A start byte accepted while stopped is consumed with the rest of its frame. Nothing is written to memory, and `drop_count` rises by one.
- R10: A memory request keeps `mem_req`, `mem_we` and `mem_addr` unchanged until `mem_ack`.
- R11: Bytes that arrive outside a frame (no start byte seen yet) are consumed and ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_valid | input | 1 | Byte present |
| rx_data | input | 8 | Frame byte |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Final byte of frame |
| rx_err | input | 1 | Frame error marker |
| rx_ready | output | 1 | Byte accepted on this edge |
| cfg_ring_base | input | ADDR_W | Ring base address (16-byte aligned) |
| cfg_buf_size | input | LEN_W | Receive buffer size in bytes, a multiple of 4 |
| desc_kick | input | 1 | Descriptors-active strobe |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables |
| mem_ack | input | 1 | Request completes this cycle |
| mem_rdata | input | 32 | Read data, valid with ack |
| evt_clr | input | 1 | Write-1 clear of the event |
| irq_en | input | 1 | Interrupt mask (1 = enabled) |
| evt_flag | output | 1 | Frame-received event |
| irq | output | 1 | Interrupt |
| drop_count | output | CNT_W | Dropped-frame count |

## Verification
A frame byte is taken on the rising edge where `rx_ready` is high. The bench drives on the falling edge and samples `rx_ready` at that point, so it knows exactly which edge consumed each byte. The closing status word lands in memory on the same edge that accepts it, and `evt_flag` rises one cycle later. The bench therefore waits for `evt_flag` at a falling edge before reading descriptors and buffers back from its memory model. `drop_count` changes one cycle after a start byte is accepted while stopped, so it is checked after the whole dropped frame has been sent. `irq` is combinational and is checked 1 ns after `irq_en` or `evt_clr` changes.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_STAT,
        ST_RD_BUF,
        ST_COLLECT,
        ST_WR_DATA,
        ST_WR_STAT
    } rx_state_e;

    localparam int BIT_EMPTY  = 15;
    localparam int BIT_WRAP   = 13;
    localparam int BIT_LAST   = 11;
    localparam int BIT_ERR    = 0;
    localparam int DESC_BYTES = 8;
    localparam int WORD_BYTES = 4;
    localparam int STAT_SH    = 16;
endpackage

// File: rtl/rxring_ptr.sv
module rxring_ptr #(
    parameter int OFF_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             wrap,
    output logic [OFF_W-1:0] offset
);
    import rxring_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            offset <= '0;
        else if (advance)
            offset <= wrap ? '0 : offset + OFF_W'(DESC_BYTES);
    end

    assert_wrap_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
        advance && wrap |=> offset == '0);
    assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !wrap |=> offset == $past(offset) + OFF_W'(DESC_BYTES));
endmodule

// File: rtl/rxring_event.sv
module rxring_event #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_done,
    input  logic             evt_clr,
    input  logic             irq_en,
    input  logic             drop_hit,
    output logic             evt_flag,
    output logic             irq,
    output logic [CNT_W-1:0] drop_count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_flag   <= 1'b0;
            drop_count <= '0;
        end else begin
            if (frame_done)
                evt_flag <= 1'b1;
            else if (evt_clr)
                evt_flag <= 1'b0;
            if (drop_hit)
                drop_count <= drop_count + CNT_W'(1);
        end
    end

    assign irq = evt_flag & irq_en;

    assert_evt_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> evt_flag);
    assert_evt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_clr && !frame_done |=> !evt_flag);
    assert_drop_inc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drop_hit |=> drop_count == $past(drop_count) + CNT_W'(1));
endmodule

// File: rtl/rxring_engine.sv
module rxring_engine
    import rxring_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int OFF_W  = 12,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              rx_err,
    output logic              rx_ready,
    input  logic [ADDR_W-1:0] cfg_ring_base,
    input  logic [LEN_W-1:0]  cfg_buf_size,
    input  logic              desc_kick,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              evt_clr,
    input  logic              irq_en,
    output logic              evt_flag,
    output logic              irq,
    output logic [CNT_W-1:0]  drop_count
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(15);

    rx_state_e         state, state_nx;
    logic [ADDR_W-1:0] buf_addr;
    logic [ADDR_W-1:0] desc_addr;
    logic [LEN_W-1:0]  dcnt, dcnt_inc, word_off;
    logic [31:0]       pack_data;
    logic [3:0]        pack_be;
    logic              done, err, in_frame, desc_wrap;
    logic [OFF_W-1:0]  ring_off;
    logic              byte_take, word_close, adv, frame_close, drop_hit, desc_empty;
    logic [15:0]       stat_out;

    assign desc_addr   = (cfg_ring_base & ALIGN_MASK) + ADDR_W'(ring_off);
    assign desc_empty  = mem_rdata[STAT_SH + BIT_EMPTY];
    assign dcnt_inc    = dcnt + LEN_W'(1);
    assign byte_take   = (state == ST_COLLECT) && rx_valid && (in_frame || rx_sof);
    assign word_close  = rx_eof || (dcnt[1:0] == 2'd3) || (dcnt_inc == cfg_buf_size);
    assign adv         = (state == ST_WR_STAT) && mem_ack;
    assign frame_close = adv && done;
    assign drop_hit    = (state == ST_IDLE) && rx_valid && rx_sof;

    rxring_ptr #(.OFF_W(OFF_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .advance(adv), .wrap(desc_wrap), .offset(ring_off)
    );

    rxring_event #(.CNT_W(CNT_W)) u_evt (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_close), .evt_clr(evt_clr),
        .irq_en(irq_en), .drop_hit(drop_hit), .evt_flag(evt_flag), .irq(irq),
        .drop_count(drop_count)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (desc_kick) state_nx = ST_RD_STAT;
            ST_RD_STAT: if (mem_ack) state_nx = desc_empty ? ST_RD_BUF : ST_IDLE;
            ST_RD_BUF:  if (mem_ack) state_nx = ST_COLLECT;
            ST_COLLECT: if (byte_take && word_close) state_nx = ST_WR_DATA;
            ST_WR_DATA: if (mem_ack)
                            state_nx = (done || dcnt == cfg_buf_size) ? ST_WR_STAT : ST_COLLECT;
            ST_WR_STAT: if (mem_ack) state_nx = ST_RD_STAT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_addr  <= '0;
            dcnt      <= '0;
            word_off  <= '0;
            pack_data <= '0;
            pack_be   <= '0;
            done      <= 1'b0;
            err       <= 1'b0;
            in_frame  <= 1'b0;
            desc_wrap <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_RD_STAT: if (mem_ack) begin
                    desc_wrap <= mem_rdata[STAT_SH + BIT_WRAP];
                    if (!desc_empty) in_frame <= 1'b0;
                end
                ST_RD_BUF: if (mem_ack) buf_addr <= mem_rdata[ADDR_W-1:0];
                ST_COLLECT: if (byte_take) begin
                    pack_data[8*dcnt[1:0] +: 8] <= rx_data;
                    pack_be[dcnt[1:0]]          <= 1'b1;
                    dcnt                        <= dcnt_inc;
                    err                         <= err | rx_err;
                    in_frame                    <= !rx_eof;
                    if (rx_eof) done <= 1'b1;
                end
                ST_WR_DATA: if (mem_ack) begin
                    pack_data <= '0;
                    pack_be   <= '0;
                    word_off  <= word_off + LEN_W'(WORD_BYTES);
                end
                ST_WR_STAT: if (mem_ack) begin
                    dcnt     <= '0;
                    word_off <= '0;
                    done     <= 1'b0;
                    if (done) err <= 1'b0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_be    = 4'h0;
        rx_ready  = 1'b0;
        stat_out  = '0;
        stat_out[BIT_WRAP] = desc_wrap;
        stat_out[BIT_LAST] = done;
        stat_out[BIT_ERR]  = done & err;
        unique case (state)
            ST_IDLE:    rx_ready = 1'b1;
            ST_RD_STAT: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr;
            end
            ST_RD_BUF:  begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + ADDR_W'(WORD_BYTES);
            end
            ST_COLLECT: rx_ready = 1'b1;
            ST_WR_DATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = buf_addr + ADDR_W'(word_off);
                mem_wdata = pack_data;
                mem_be    = pack_be;
            end
            ST_WR_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr;
                mem_wdata = {stat_out, 16'(dcnt)};
                mem_be    = 4'hF;
            end
        endcase
    end

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
    assert_stopped_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> rx_ready && !mem_req);
    assert_be_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WR_DATA |-> mem_be != 4'h0);
    assert_close_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WR_STAT |-> mem_wdata[15:0] != 16'h0 && !mem_wdata[STAT_SH + BIT_EMPTY]);
endmodule

// File: tb/rxring_engine_test.sv
module rxring_engine_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_valid, rx_sof, rx_eof, rx_err;
    logic [7:0]  rx_data;
    logic        rx_ready;
    logic [31:0] cfg_ring_base;
    logic [15:0] cfg_buf_size;
    logic        desc_kick;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;
    logic        evt_clr, irq_en, evt_flag, irq;
    logic [15:0] drop_count;

    logic [31:0] mem [0:255];
    logic        tb_we;
    logic [7:0]  tb_wa;
    logic [31:0] tb_wd;
    int          rd_cnt, wr_cnt, viol;
    logic [31:0] last_rd, first_rd, pend_addr;
    logic        pend;
    int          checks = 0, failures = 0;

    always #10 clk = ~clk;

    rxring_engine uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err), .rx_ready(rx_ready),
        .cfg_ring_base(cfg_ring_base), .cfg_buf_size(cfg_buf_size), .desc_kick(desc_kick),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .evt_clr(evt_clr),
        .irq_en(irq_en), .evt_flag(evt_flag), .irq(irq), .drop_count(drop_count)
    );

    // memory model: sole owner of mem
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 32'h5A5A5A5A;
            rd_cnt <= 0; wr_cnt <= 0; viol <= 0; pend <= 1'b0;
            last_rd <= '0; first_rd <= '0; pend_addr <= '0;
        end else begin
            if (pend && (!mem_req || mem_addr != pend_addr)) viol <= viol + 1;
            pend      <= mem_req && !mem_ack;
            pend_addr <= mem_addr;
            if (mem_req && mem_ack) begin
                if (mem_we) begin
                    for (int k = 0; k < 4; k++)
                        if (mem_be[k]) mem[mem_addr[9:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    if (rd_cnt == 0) first_rd <= mem_addr;
                    last_rd <= mem_addr;
                    rd_cnt  <= rd_cnt + 1;
                end
            end
            if (tb_we) mem[tb_wa] <= tb_wd;
        end
    end

    always @(negedge clk) begin
        mem_ack   <= mem_req && (($urandom % 4) != 0);
        mem_rdata <= mem[mem_addr[9:2]];
    end

    function automatic logic [7:0] fbyte(input int tag, input int i);
        return 8'(tag * 37 + i * 11 + 3);
    endfunction

    function automatic logic [31:0] exp_stat(input bit wrap, input bit last, input bit e, input int len);
        logic [15:0] s;
        s = '0;
        s[13] = wrap;
        s[11] = last;
        s[0]  = last & e;
        return {s, 16'(len)};
    endfunction

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return mem[a[9:2]][{a[1:0], 3'b000} +: 8];
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] addr, input logic [31:0] data);
        tb_we = 1'b1; tb_wa = addr[9:2]; tb_wd = data;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic arm(input int idx, input bit wrap);
        poke(32'h40 + 32'(idx * 8), {1'b1, 1'b0, wrap, 13'h0, 16'h0});
        poke(32'h44 + 32'(idx * 8), 32'h100 * 32'(idx + 1));
    endtask

    task automatic kick();
        desc_kick = 1'b1;
        @(negedge clk);
        desc_kick = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, input bit s, input bit e, input bit er);
        bit ok;
        rx_valid = 1'b1; rx_data = d; rx_sof = s; rx_eof = e; rx_err = er;
        forever begin
            ok = rx_ready;
            @(negedge clk);
            if (ok) break;
        end
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
    endtask

    task automatic send_frame(input int tag, input int len, input bit er);
        for (int i = 0; i < len; i++)
            send_byte(fbyte(tag, i), i == 0, i == len - 1, er && (i == len - 1));
    endtask

    task automatic wait_evt(input string req);
        int n = 0;
        while (!evt_flag && n < 5000) begin @(negedge clk); n++; end
        check(evt_flag, req, 32'(evt_flag), 32'd1);
    endtask

    task automatic clear_evt();
        evt_clr = 1'b1;
        @(negedge clk);
        evt_clr = 1'b0;
    endtask

    task automatic check_data(input string req, input logic [31:0] base, input int tag,
                              input int start, input int len);
        int mism = 0;
        for (int i = 0; i < len; i++)
            if (mem_byte(base + 32'(i)) != fbyte(tag, start + i)) mism++;
        check(mism == 0, req, 32'(mism), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        int p;
        void'($urandom(32'd4321));
        rst_n = 1'b0; rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0; rx_data = '0;
        cfg_ring_base = 32'h4B; cfg_buf_size = 16'd64; desc_kick = 0;
        evt_clr = 0; irq_en = 0; tb_we = 0; tb_wa = '0; tb_wd = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(!mem_req, "R1 mem_req", 32'(mem_req), 0);
        check(!evt_flag, "R1 evt_flag", 32'(evt_flag), 0);
        check(drop_count == 0, "R1 drop_count", 32'(drop_count), 0);
        check(rx_ready, "R1 rx_ready", 32'(rx_ready), 1);
        repeat (10) @(negedge clk);
        check(rd_cnt == 0, "R1 no fetch before kick", 32'(rd_cnt), 0);

        arm(0, 0); arm(1, 0); arm(2, 1);

        // R9 frame while stopped is dropped
        send_frame(9, 10, 0);
        check(drop_count == 1, "R9 drop count", 32'(drop_count), 1);
        check(wr_cnt == 0, "R9 no write", 32'(wr_cnt), 0);

        // R2 fetch addresses
        kick();
        n = 0;
        while (rd_cnt < 2 && n < 200) begin @(negedge clk); n++; end
        check(first_rd == 32'h40, "R2 status read at aligned base", first_rd, 32'h40);
        check(last_rd == 32'h44, "R2 buffer read at base+4", last_rd, 32'h44);

        // R11 stray byte, then frame A
        send_byte(8'hC3, 0, 0, 0);
        send_frame(1, 20, 0);
        wait_evt("R8 event after frame A");
        check(mem[16] == exp_stat(0, 1, 0, 20), "R5 frame A status", mem[16], exp_stat(0, 1, 0, 20));
        check_data("R4 R11 frame A data", 32'h100, 1, 0, 20);
        check(!irq, "R8 irq masked", 32'(irq), 0);
        irq_en = 1'b1; #1;
        check(irq, "R8 irq enabled", 32'(irq), 1);
        clear_evt();
        check(!evt_flag && !irq, "R8 clear", {evt_flag, irq}, 0);

        // frame B with error, partial word
        send_frame(2, 5, 1);
        wait_evt("R8 event after frame B");
        check(mem[18] == exp_stat(0, 1, 1, 5), "R5 frame B status", mem[18], exp_stat(0, 1, 1, 5));
        check_data("R4 frame B data", 32'h200, 2, 0, 5);
        check({mem_byte(32'h205), mem_byte(32'h206), mem_byte(32'h207)} == 24'h5A5A5A,
              "R4 bytes past end unchanged", mem[32'h204 >> 2], 32'h5A5A5A00);
        clear_evt();

        // frame C on wrap descriptor, then stop on owned descriptor
        send_frame(3, 7, 0);
        wait_evt("R8 event after frame C");
        check(mem[20] == exp_stat(1, 1, 0, 7), "R5 frame C status", mem[20], exp_stat(1, 1, 0, 7));
        clear_evt();
        repeat (20) @(negedge clk);
        check(last_rd == 32'h40, "R6 fetch returns to base", last_rd, 32'h40);
        n = rd_cnt;
        repeat (20) @(negedge clk);
        check(rd_cnt == n && !mem_req, "R3 stopped", 32'(rd_cnt), 32'(n));
        send_frame(4, 6, 0);
        check(drop_count == 2, "R9 second drop", 32'(drop_count), 2);

        // R7 spill across three descriptors
        cfg_buf_size = 16'd16;
        arm(0, 0); arm(1, 0); arm(2, 1);
        kick();
        send_frame(5, 40, 0);
        wait_evt("R8 event after spill");
        check(mem[16] == exp_stat(0, 0, 0, 16), "R7 spill desc0", mem[16], exp_stat(0, 0, 0, 16));
        check(mem[18] == exp_stat(0, 0, 0, 16), "R7 spill desc1", mem[18], exp_stat(0, 0, 0, 16));
        check(mem[20] == exp_stat(1, 1, 0, 8), "R7 spill desc2", mem[20], exp_stat(1, 1, 0, 8));
        check_data("R7 spill data 0", 32'h100, 5, 0, 16);
        check_data("R7 spill data 1", 32'h200, 5, 16, 16);
        check_data("R7 spill data 2", 32'h300, 5, 32, 8);
        clear_evt();

        // random frames, single descriptor each
        cfg_buf_size = 16'd64;
        p = 0;
        for (int it = 0; it < 20; it++) begin
            int  len;
            bit  g, e;
            len = int'($urandom_range(1, 64));
            g   = ($urandom % 2) == 0;
            e   = ($urandom % 4) == 0;
            arm(0, 0); arm(1, 0); arm(2, 1);
            kick();
            if (g) send_byte(8'hC3, 0, 0, 0);
            send_frame(10 + it, len, e);
            wait_evt("R8 random event");
            check(mem[16 + 2 * p] == exp_stat(p == 2, 1, e, len), "R5 R6 random status",
                  mem[16 + 2 * p], exp_stat(p == 2, 1, e, len));
            check_data("R4 R11 random data", 32'h100 * 32'(p + 1), 10 + it, 0, len);
            clear_evt();
            p = (p + 1) % 3;
        end

        check(viol == 0, "R10 request held until ack", 32'(viol), 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule